// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block turns a byte stream from instruction memory into one decoded instruction at a time for a 16-bit processor with sixteen registers. Every instruction opens with a header byte. The two top bits of the header select one of four classes: arithmetic/logic, memory, jump and system. The remaining header bits carry the operation and flags saying which operands are immediates. From the header alone the decoder works out how many operand bytes follow. It collects them and then presents register indices, immediates, class-specific controls and the total length in bytes, so that the fetch unit can advance the program counter.

A register operand takes one byte, and only its low four bits give the register index. An immediate operand takes two bytes, low byte first. The instruction length is one plus the sizes of its operands, which gives 1 to 5 bytes.

The decoder is a three-state machine:
- **IDLE** waits for the header byte. On *accept-header* it goes to **GATHER** when the header needs operands. A system header needs none, so it goes straight to **OFFER**.
- **GATHER** takes operand bytes. On *last-byte* it goes to **OFFER**.
- **OFFER** holds the decoded result valid until the consumer takes it. On *handoff* it returns to **IDLE**.

While the machine is in **OFFER**, no input byte is accepted.

Top module: `insn_decoder`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The header's bits [7:6] give `out_cls` (00 arithmetic, 01 memory, 10 jump, 11 system). `out_valid` rises in the cycle after the last byte of the instruction is accepted, and not earlier. `out_len` equals 1 plus the operand sizes, where a register operand is 1 byte and an immediate is 2 bytes.
- R3: Arithmetic class. Bits [5:3] give `out_op` (000 add, 001 sub, 010 div, 011 mul, 100 xor, 101 shift, 110 and, 111 or), and bit 0 marks operand B as immediate. The operands arrive in the order source A (register), B, then destination C (register). `out_wr_en` is 1.
- R4: Memory class. The flags are bit 5 store (1) or load (0), bit 4 high, bit 3 word, bit 1 address operand immediate, and bit 0 value operand immediate. `out_op` is {bit5, bit4, bit3}. The address operand comes first. For a store the value operand appears in `out_reg_b` or `out_imm_b`. For a load bit 0 is ignored: the second operand is a single register byte that goes to `out_reg_d`, and `out_wr_en` is 1.
- R5: Jump class. Bits [5:4] give the condition (00 greater than zero, 01 less than zero, 10 equal to zero) and appear on `out_op[1:0]`. The first operand is the tested register, on `out_reg_a`. Bit 0 marks the target as immediate (`out_imm_b`); otherwise the target register appears on `out_reg_b`.
- R6: System class. The header is the whole instruction (`out_len` is 1). `out_op[0]` is header bit 5 (1 software interrupt, 0 halt until interrupt).
- R7: `out_no_effect` is 1 exactly when `out_wr_en` is 1 and `out_reg_d` is 0.
- R8: `out_illegal` is 1 exactly for a jump header whose condition is 11.
- R9: Idle cycles of `in_valid` between bytes do not change the decoded result.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output holds its value and `in_ready` is 0. One cycle after a handoff, `out_valid` is 0 and `in_ready` is 1.
- R11: The upper four bits of a register operand byte are ignored. Fields that the class does not use read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | The decoder accepts a byte this cycle |
| out_ready | input | 1 | The consumer takes the decoded instruction |
| out_valid | output | 1 | A decoded instruction is presented |
| out_cls | output | 2 | Instruction class |
| out_op | output | 3 | Operation, memory flags, condition or system select |
| out_a_imm | output | 1 | First operand is an immediate |
| out_b_imm | output | 1 | Second operand is an immediate |
| out_reg_a | output | 4 | First source register index |
| out_reg_b | output | 4 | Second source register index |
| out_reg_d | output | 4 | Destination register index |
| out_imm_a | output | 16 | Immediate of the first operand |
| out_imm_b | output | 16 | Immediate of the second operand |
| out_wr_en | output | 1 | The instruction writes a register |
| out_no_effect | output | 1 | The register write targets register 0 |
| out_illegal | output | 1 | The condition code is undefined |
| out_len | output | 3 | Instruction length in bytes |

## Verification
Two events can fall in the same cycle. The consumer may hand off a result while, in that same cycle, the producer already offers the next header byte. The bench provokes this by keeping `in_valid` high while it pulses `out_ready`. It judges the outcome by checking that the byte was not taken during **OFFER**: the next instruction must still decode with its exact expected length and fields. A second collision comes from the header itself. A memory or arithmetic write to register 0 can sit in the same instruction as immediate operands, so the no-effect flag and the length arithmetic are checked together on the same result.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int REG_W   = 4;
    localparam int OP_W    = 3;
    localparam int NSLOT   = 3;
    localparam int LEN_W   = 3;
    localparam int SIDX_W  = $clog2(NSLOT);

    typedef enum logic [1:0] {
        CLS_ALU = 2'b00,
        CLS_MEM = 2'b01,
        CLS_JMP = 2'b10,
        CLS_SYS = 2'b11
    } cls_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_REG  = 2'd1,
        K_IMM  = 2'd2
    } kind_e;

    function automatic logic [1:0] kind_bytes(input logic [1:0] k);
        case (k)
            K_REG:   kind_bytes = 2'd1;
            K_IMM:   kind_bytes = 2'd2;
            default: kind_bytes = 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/insn_hdr_decode.sv
module insn_hdr_decode
    import insn_dec_pkg::*;
(
    input  logic [BYTE_W-1:0]           hdr,
    output logic [NSLOT-1:0][1:0]       kinds,
    output logic [LEN_W-1:0]            len
);
    always_comb begin
        kinds = '0;
        unique case (cls_e'(hdr[7:6]))
            CLS_ALU: begin
                kinds[0] = K_REG;
                kinds[1] = hdr[0] ? K_IMM : K_REG;
                kinds[2] = K_REG;
            end
            CLS_MEM: begin
                kinds[0] = hdr[1] ? K_IMM : K_REG;
                kinds[1] = (hdr[5] && hdr[0]) ? K_IMM : K_REG;
            end
            CLS_JMP: begin
                kinds[0] = K_REG;
                kinds[1] = hdr[0] ? K_IMM : K_REG;
            end
            CLS_SYS: kinds = '0;
        endcase
    end

    always_comb begin
        len = LEN_W'(1);
        for (int i = 0; i < NSLOT; i++)
            len = len + LEN_W'(kind_bytes(kinds[i]));
    end
endmodule

// File: rtl/insn_field_map.sv
module insn_field_map
    import insn_dec_pkg::*;
(
    input  logic [BYTE_W-1:0]             hdr,
    input  logic [NSLOT-1:0][DATA_W-1:0]  slots,
    output logic [OP_W-1:0]               op,
    output logic                          a_imm,
    output logic                          b_imm,
    output logic [REG_W-1:0]              reg_a,
    output logic [REG_W-1:0]              reg_b,
    output logic [REG_W-1:0]              reg_d,
    output logic [DATA_W-1:0]             imm_a,
    output logic [DATA_W-1:0]             imm_b,
    output logic                          wr_en,
    output logic                          no_effect,
    output logic                          illegal
);
    always_comb begin
        op = '0; a_imm = 1'b0; b_imm = 1'b0;
        reg_a = '0; reg_b = '0; reg_d = '0;
        imm_a = '0; imm_b = '0;
        wr_en = 1'b0; illegal = 1'b0;
        unique case (cls_e'(hdr[7:6]))
            CLS_ALU: begin
                op    = hdr[5:3];
                b_imm = hdr[0];
                reg_a = slots[0][REG_W-1:0];
                if (hdr[0]) imm_b = slots[1];
                else        reg_b = slots[1][REG_W-1:0];
                reg_d = slots[2][REG_W-1:0];
                wr_en = 1'b1;
            end
            CLS_MEM: begin
                op    = hdr[5:3];
                a_imm = hdr[1];
                if (hdr[1]) imm_a = slots[0];
                else        reg_a = slots[0][REG_W-1:0];
                if (hdr[5]) begin
                    b_imm = hdr[0];
                    if (hdr[0]) imm_b = slots[1];
                    else        reg_b = slots[1][REG_W-1:0];
                end else begin
                    reg_d = slots[1][REG_W-1:0];
                    wr_en = 1'b1;
                end
            end
            CLS_JMP: begin
                op      = {1'b0, hdr[5:4]};
                b_imm   = hdr[0];
                reg_a   = slots[0][REG_W-1:0];
                if (hdr[0]) imm_b = slots[1];
                else        reg_b = slots[1][REG_W-1:0];
                illegal = (hdr[5:4] == 2'b11);
            end
            CLS_SYS: op = {2'b00, hdr[5]};
        endcase
        no_effect = wr_en && (reg_d == '0);
    end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
    import insn_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic               in_ready,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [1:0]         out_cls,
    output logic [2:0]         out_op,
    output logic               out_a_imm,
    output logic               out_b_imm,
    output logic [3:0]         out_reg_a,
    output logic [3:0]         out_reg_b,
    output logic [3:0]         out_reg_d,
    output logic [15:0]        out_imm_a,
    output logic [15:0]        out_imm_b,
    output logic               out_wr_en,
    output logic               out_no_effect,
    output logic               out_illegal,
    output logic [2:0]         out_len
);
    typedef enum logic [1:0] {ST_IDLE, ST_GATHER, ST_OFFER} state_e;

    state_e                       state_q, state_nx;
    logic [BYTE_W-1:0]            hdr_q;
    logic [NSLOT-1:0][DATA_W-1:0] slots_q;
    logic [SIDX_W-1:0]            slot_idx;
    logic                         byte_hi;

    logic [BYTE_W-1:0]            dec_hdr;
    logic [NSLOT-1:0][1:0]        kinds;
    logic [NSLOT-1:0]             more;
    logic [LEN_W-1:0]             len_w;
    logic                         take, slot_done;

    assign dec_hdr = (state_q == ST_IDLE) ? in_byte : hdr_q;

    insn_hdr_decode u_hdr (
        .hdr   (dec_hdr),
        .kinds (kinds),
        .len   (len_w)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_more
        if (g < NSLOT - 1) begin : g_mid
            assign more[g] = (kinds[g+1] != K_NONE);
        end else begin : g_end
            assign more[g] = 1'b0;
        end
    end

    assign take      = in_valid && in_ready;
    assign slot_done = (kinds[slot_idx] == K_REG) || byte_hi;

    // Next-state and handshake outputs
    always_comb begin
        state_nx  = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                if (take)
                    state_nx = (kinds[0] == K_NONE) ? ST_OFFER : ST_GATHER;
            end
            ST_GATHER: begin
                in_ready = 1'b1;
                if (take && slot_done && !more[slot_idx])
                    state_nx = ST_OFFER;
            end
            ST_OFFER: begin
                out_valid = 1'b1;
                if (out_ready) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Header and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q    <= '0;
            slots_q  <= '0;
            slot_idx <= '0;
            byte_hi  <= 1'b0;
        end else if (take) begin
            if (state_q == ST_IDLE) begin
                hdr_q    <= in_byte;
                slot_idx <= '0;
                byte_hi  <= 1'b0;
            end else begin
                if (kinds[slot_idx] == K_REG)
                    slots_q[slot_idx] <= {{(DATA_W-BYTE_W){1'b0}}, in_byte};
                else if (!byte_hi)
                    slots_q[slot_idx][BYTE_W-1:0] <= in_byte;
                else
                    slots_q[slot_idx][DATA_W-1:BYTE_W] <= in_byte;
                if (slot_done) begin
                    byte_hi <= 1'b0;
                    if (more[slot_idx]) slot_idx <= slot_idx + SIDX_W'(1);
                end else begin
                    byte_hi <= 1'b1;
                end
            end
        end
    end

    insn_field_map u_map (
        .hdr       (hdr_q),
        .slots     (slots_q),
        .op        (out_op),
        .a_imm     (out_a_imm),
        .b_imm     (out_b_imm),
        .reg_a     (out_reg_a),
        .reg_b     (out_reg_b),
        .reg_d     (out_reg_d),
        .imm_a     (out_imm_a),
        .imm_b     (out_imm_b),
        .wr_en     (out_wr_en),
        .no_effect (out_no_effect),
        .illegal   (out_illegal)
    );

    assign out_cls = hdr_q[7:6];
    assign out_len = len_w;

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_len) && $stable(out_op)
            && $stable(out_imm_a) && $stable(out_imm_b) && $stable(out_reg_d));
    // R10
    in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R10
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);
    // R2
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len >= 3'd1) && (out_len <= 3'd5));
    // R6
    sys_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_cls == 2'b11) |-> (out_len == 3'd1));
    // R8
    illegal_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_cls == 2'b10));
    // R7
    no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_no_effect |-> out_wr_en && (out_reg_d == 4'd0));
endmodule

// File: tb/insn_decoder_tb_top.sv
module insn_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        in_ready;
    logic        out_ready;
    logic        out_valid;
    logic [1:0]  out_cls;
    logic [2:0]  out_op;
    logic        out_a_imm, out_b_imm;
    logic [3:0]  out_reg_a, out_reg_b, out_reg_d;
    logic [15:0] out_imm_a, out_imm_b;
    logic        out_wr_en, out_no_effect, out_illegal;
    logic [2:0]  out_len;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    insn_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
        .out_cls(out_cls), .out_op(out_op), .out_a_imm(out_a_imm),
        .out_b_imm(out_b_imm), .out_reg_a(out_reg_a), .out_reg_b(out_reg_b),
        .out_reg_d(out_reg_d), .out_imm_a(out_imm_a), .out_imm_b(out_imm_b),
        .out_wr_en(out_wr_en), .out_no_effect(out_no_effect),
        .out_illegal(out_illegal), .out_len(out_len)
    );

    logic [7:0]  ib [5];
    int          nb;
    logic [15:0] sv [3];
    int          e_cls, e_op, e_aimm, e_bimm, e_ra, e_rb, e_rd;
    int          e_ia, e_ib, e_we, e_ne, e_ill, e_len;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int opsz(input logic [7:0] h, input int i);
        case (h[7:6])
            2'b00:   return (i == 1) ? (h[0] ? 2 : 1) : 1;
            2'b01:   return (i == 0) ? (h[1] ? 2 : 1) : (i == 1) ? ((h[5] & h[0]) ? 2 : 1) : 0;
            2'b10:   return (i == 1) ? (h[0] ? 2 : 1) : (i == 0) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    // Build an instruction with random operand bytes and its expected decode
    task automatic build(input logic [7:0] h);
        ib[0] = h; nb = 1;
        for (int i = 0; i < 3; i++) begin
            int s = opsz(h, i);
            sv[i] = 16'h0;
            if (s == 1) begin
                ib[nb] = 8'($urandom); sv[i] = {8'h00, ib[nb]}; nb++;
            end else if (s == 2) begin
                ib[nb] = 8'($urandom); ib[nb+1] = 8'($urandom);
                sv[i] = {ib[nb+1], ib[nb]}; nb += 2;
            end
        end
        e_len = nb; e_cls = h[7:6];
        e_op = 0; e_aimm = 0; e_bimm = 0; e_ra = 0; e_rb = 0; e_rd = 0;
        e_ia = 0; e_ib = 0; e_we = 0; e_ill = 0;
        case (h[7:6])
            2'b00: begin
                e_op = h[5:3]; e_bimm = h[0]; e_ra = sv[0][3:0];
                if (h[0]) e_ib = sv[1]; else e_rb = sv[1][3:0];
                e_rd = sv[2][3:0]; e_we = 1;
            end
            2'b01: begin
                e_op = h[5:3]; e_aimm = h[1];
                if (h[1]) e_ia = sv[0]; else e_ra = sv[0][3:0];
                if (h[5]) begin
                    e_bimm = h[0];
                    if (h[0]) e_ib = sv[1]; else e_rb = sv[1][3:0];
                end else begin
                    e_rd = sv[1][3:0]; e_we = 1;
                end
            end
            2'b10: begin
                e_op = h[5:4]; e_bimm = h[0]; e_ra = sv[0][3:0];
                if (h[0]) e_ib = sv[1]; else e_rb = sv[1][3:0];
                e_ill = (h[5:4] == 2'b11);
            end
            default: e_op = h[5];
        endcase
        e_ne = (e_we == 1 && e_rd == 0);
    endtask

    task automatic check_fields();
        string ct;
        case (e_cls)
            0: ct = "R3"; 1: ct = "R4"; 2: ct = "R5"; default: ct = "R6";
        endcase
        chk("R2", "cls", out_cls, e_cls);
        chk("R2", "len", out_len, e_len);
        chk(ct, "op", out_op, e_op);
        chk(ct, "a_imm", out_a_imm, e_aimm);
        chk(ct, "b_imm", out_b_imm, e_bimm);
        chk("R11", "reg_a", out_reg_a, e_ra);
        chk("R11", "reg_b", out_reg_b, e_rb);
        chk("R11", "reg_d", out_reg_d, e_rd);
        chk(ct, "imm_a", out_imm_a, e_ia);
        chk(ct, "imm_b", out_imm_b, e_ib);
        chk(ct, "wr_en", out_wr_en, e_we);
        chk("R7", "no_effect", out_no_effect, e_ne);
        chk("R8", "illegal", out_illegal, e_ill);
    endtask

    // Drive the built bytes with random gaps, then check and hand off
    task automatic run_one(input logic [7:0] h, input bit overlap);
        build(h);
        for (int k = 0; k < nb; k++) begin
            int gap = $urandom % 3;
            repeat (gap) @(negedge clk);
            chk("R9", "in_ready before byte", in_ready, 1);
            in_valid = 1'b1; in_byte = ib[k];
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            if (k < nb - 1) chk("R2", "early out_valid", out_valid, 0);
        end
        chk("R2", "out_valid after last byte", out_valid, 1);
        check_fields();
        begin
            int hold = $urandom % 3;
            for (int j = 0; j < hold; j++) begin
                @(negedge clk);
                chk("R10", "in_ready while held", in_ready, 0);
                chk("R10", "out_valid held", out_valid, 1);
                chk("R10", "len held", out_len, e_len);
                chk("R10", "imm_b held", out_imm_b, e_ib);
            end
        end
        out_ready = 1'b1;
        if (overlap) begin
            in_valid = 1'b1; in_byte = 8'hC0;
        end
        @(posedge clk); @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b0;
        chk("R10", "out_valid after handoff", out_valid, 0);
        chk("R10", "in_ready after handoff", in_ready, 1);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "out_valid at reset", out_valid, 0);
        chk("R1", "in_ready at reset", in_ready, 1);

        run_one(8'b00_000_000, 1'b0);  // add, all registers, len 4
        run_one(8'b00_111_001, 1'b1);  // or, B immediate, len 5
        run_one(8'b01_101_011, 1'b0);  // store word, both immediates, len 5
        run_one(8'b01_000_001, 1'b0);  // load: value flag ignored, len 3
        run_one(8'b01_011_010, 1'b0);  // load high word, imm address, len 4
        run_one(8'b10_000_001, 1'b1);  // jump >0, imm target, len 4
        run_one(8'b10_110_000, 1'b0);  // illegal condition
        run_one(8'b11_100_000, 1'b0);  // software interrupt
        run_one(8'b11_000_000, 1'b1);  // halt
        for (int n = 0; n < 400; n++)
            run_one(8'($urandom), 1'($urandom));

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule